// File: doc/BRIEF.md
# Vertical Line-Count Frame Timing Meter

This block measures the vertical timing of a video frame in units of horizontal lines. It takes one-clock event pulses that have already been edge-detected and polarity-corrected: a horizontal line pulse, the V-sync leading and trailing edges, and markers for the first and last active lines. A 12-bit line counter restarts at each V-sync leading edge and advances once per line pulse. During the frame, the line number reached at each of three events is latched into a buffer: the V-sync trailing edge, the first active line and the last active line.

At the next V-sync leading edge, the buffers, the frame's total line count and a sticky overflow indication are copied into read registers. Those registers then hold a stable snapshot of the previous frame for a whole frame. Each count is presented as a 16-bit word, with the count in the upper 12 bits and zeros below. Frames of differing length, such as those from interlaced sources, are reported exactly as counted, with no special recognition.

Top module: `vline_meter`

## Requirements
- R1: After reset all read words, `rd_overflow` and `rd_valid` are zero.
- R2: Each `hs_pulse` without a coincident `vs_lead_pulse` raises the line count by one. `rd_frame_lines` reports the number of line pulses counted between two consecutive V-sync leading edges, including frames of unequal length.
- R3: A `vs_trail_pulse` latches the current line number, including any line pulse in the same clock, as the sync width. It is reported in `rd_sync_width` after the next leading edge.
- R4: `act_first_pulse` and `act_last_pulse` latch the current line number, including a same-clock line pulse. A later marker of the same kind in the frame overwrites the earlier one. A marker that is absent from a frame is reported as 0.
- R5: The read words and `rd_overflow` change only in the clock after a `vs_lead_pulse`, and hold their values at every other time.
- R6: Every read word is {count[11:0], 4'b0000}. Bits 3:0 are always zero.
- R7: The line count saturates at 4095 and does not wrap. A line pulse arriving while the count is 4095 sets an overflow flag for the frame. That flag is reported in `rd_overflow` with the frame's results and cleared for the next frame.
- R8: When `hs_pulse` and `vs_lead_pulse` arrive in the same clock, the finishing frame's total excludes that line pulse, and the pulse is counted as line 1 of the new frame.
- R9: The first `vs_lead_pulse` after reset starts measurement without updating the read registers. From the second leading edge on, every leading edge transfers results, and `rd_valid` is set by the first transfer and stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hs_pulse | input | 1 | One-clock pulse per horizontal line |
| vs_lead_pulse | input | 1 | One-clock pulse at the V-sync leading edge |
| vs_trail_pulse | input | 1 | One-clock pulse at the V-sync trailing edge |
| act_first_pulse | input | 1 | One-clock marker at the first active line |
| act_last_pulse | input | 1 | One-clock marker at the last active line |
| rd_sync_width | output | 16 | Sync width in lines, count in bits 15:4 |
| rd_first_act | output | 16 | Line number of the first active line, bits 15:4 |
| rd_last_act | output | 16 | Line number of the last active line, bits 15:4 |
| rd_frame_lines | output | 16 | Total lines of the previous frame, bits 15:4 |
| rd_overflow | output | 1 | Line count of the previous frame saturated |
| rd_valid | output | 1 | At least one complete frame has been reported |

## Verification
The bench aims line pulses at the same clock as each event. A design that latched the registered count instead of the updated one would report every marker one line short. A design that let a coincident line pulse land in the old frame would report a total one too high and start the new frame at 0.

A frame of more than 4096 lines checks that a wrapping counter, which would report a small total, is caught, and that the overflow flag clears on the following frame. Frames with missing and repeated markers, and a first partial frame, expose stale buffers and a premature `rd_valid`. Alternating frame lengths show that nothing is averaged or merged between frames.

// File: rtl/vlm_pkg.sv
package vlm_pkg;

  typedef enum int unsigned {
    MK_SYNC  = 0,
    MK_FIRST = 1,
    MK_LAST  = 2,
    MK_COUNT = 3
  } mark_e;

  // Saturating increment: v + 1, held at maxv.
  function automatic logic [31:0] sat_inc(input logic [31:0] v, input logic [31:0] maxv);
    return (v >= maxv) ? maxv : v + 32'd1;
  endfunction

  // Place a count in the upper bits of a word, zero below.
  function automatic logic [31:0] pad_low(input logic [31:0] v, input int unsigned sh);
    return v << sh;
  endfunction

endpackage

// File: rtl/vlm_line_counter.sv
module vlm_line_counter #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hs,
  input  logic             vs_lead,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             ovf_q,
  output logic             sat_hit
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic ovf_nxt;

  always_comb begin
    sat_hit = hs && !vs_lead && (cnt_q == CNT_MAX);
    if (vs_lead) begin
      cnt_nxt = hs ? CNT_W'(1) : '0;
      ovf_nxt = 1'b0;
    end else begin
      cnt_nxt = hs ? CNT_W'(vlm_pkg::sat_inc(32'(cnt_q), 32'(CNT_MAX))) : cnt_q;
      ovf_nxt = ovf_q || sat_hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      ovf_q <= ovf_nxt;
    end
  end
endmodule

// File: rtl/vlm_capture_bank.sv
module vlm_capture_bank #(
  parameter int unsigned CNT_W  = 12,
  parameter int unsigned N_MARK = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         vs_lead,
  input  logic [N_MARK-1:0]            mark,
  input  logic [CNT_W-1:0]             cnt_nxt,
  output logic [N_MARK-1:0][CNT_W-1:0] buf_q
);
  for (genvar i = 0; i < N_MARK; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       buf_q[i] <= '0;
      else if (mark[i]) buf_q[i] <= cnt_nxt;
      else if (vs_lead) buf_q[i] <= '0;
    end
  end
endmodule

// File: rtl/vlm_readout.sv
module vlm_readout #(
  parameter int unsigned CNT_W  = 12,
  parameter int unsigned N_MARK = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         vs_lead,
  input  logic [N_MARK-1:0][CNT_W-1:0] buf_q,
  input  logic [CNT_W-1:0]             total,
  input  logic                         ovf,
  output logic [N_MARK-1:0][CNT_W-1:0] rd_mark,
  output logic [CNT_W-1:0]             rd_total,
  output logic                         rd_ovf,
  output logic                         rd_valid,
  output logic                         xfer
);
  logic armed_q;

  assign xfer = vs_lead && armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q  <= 1'b0;
      rd_valid <= 1'b0;
      rd_mark  <= '0;
      rd_total <= '0;
      rd_ovf   <= 1'b0;
    end else begin
      if (vs_lead) armed_q <= 1'b1;
      if (xfer) begin
        rd_mark  <= buf_q;
        rd_total <= total;
        rd_ovf   <= ovf;
        rd_valid <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/vline_meter.sv
module vline_meter #(
  parameter int unsigned CNT_W  = 12,
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hs_pulse,
  input  logic              vs_lead_pulse,
  input  logic              vs_trail_pulse,
  input  logic              act_first_pulse,
  input  logic              act_last_pulse,
  output logic [WORD_W-1:0] rd_sync_width,
  output logic [WORD_W-1:0] rd_first_act,
  output logic [WORD_W-1:0] rd_last_act,
  output logic [WORD_W-1:0] rd_frame_lines,
  output logic              rd_overflow,
  output logic              rd_valid
);
  import vlm_pkg::*;
  localparam int unsigned N_MARK = MK_COUNT;
  localparam int unsigned PAD_W  = WORD_W - CNT_W;

  logic [CNT_W-1:0]             line_cnt;
  logic [CNT_W-1:0]             line_nxt;
  logic                         frame_ovf;
  logic                         sat_hit;
  logic [N_MARK-1:0]            mark;
  logic [N_MARK-1:0][CNT_W-1:0] buf_q;
  logic [N_MARK-1:0][CNT_W-1:0] rd_mark;
  logic [CNT_W-1:0]             rd_total;
  logic                         xfer;
  logic [N_MARK:0][WORD_W-1:0]  word;

  always_comb begin
    mark           = '0;
    mark[MK_SYNC]  = vs_trail_pulse;
    mark[MK_FIRST] = act_first_pulse;
    mark[MK_LAST]  = act_last_pulse;
  end

  vlm_line_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .hs(hs_pulse), .vs_lead(vs_lead_pulse),
    .cnt_q(line_cnt), .cnt_nxt(line_nxt), .ovf_q(frame_ovf), .sat_hit(sat_hit)
  );

  vlm_capture_bank #(.CNT_W(CNT_W), .N_MARK(N_MARK)) u_bank (
    .clk(clk), .rst_n(rst_n), .vs_lead(vs_lead_pulse), .mark(mark),
    .cnt_nxt(line_nxt), .buf_q(buf_q)
  );

  vlm_readout #(.CNT_W(CNT_W), .N_MARK(N_MARK)) u_rd (
    .clk(clk), .rst_n(rst_n), .vs_lead(vs_lead_pulse), .buf_q(buf_q),
    .total(line_cnt), .ovf(frame_ovf), .rd_mark(rd_mark), .rd_total(rd_total),
    .rd_ovf(rd_overflow), .rd_valid(rd_valid), .xfer(xfer)
  );

  for (genvar i = 0; i <= N_MARK; i++) begin : g_word
    if (i < N_MARK) begin : g_mark
      assign word[i] = WORD_W'(pad_low(32'(rd_mark[i]), PAD_W));
    end else begin : g_total
      assign word[i] = WORD_W'(pad_low(32'(rd_total), PAD_W));
    end
  end

  assign rd_sync_width  = word[MK_SYNC];
  assign rd_first_act   = word[MK_FIRST];
  assign rd_last_act    = word[MK_LAST];
  assign rd_frame_lines = word[N_MARK];
endmodule

// File: rtl/vlm_checker.sv
module vlm_checker #(
  parameter int unsigned CNT_W  = 12,
  parameter int unsigned WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hs,
  input logic              vs_lead,
  input logic              xfer,
  input logic [CNT_W-1:0]  cnt,
  input logic [WORD_W-1:0] w_sync,
  input logic [WORD_W-1:0] w_first,
  input logic [WORD_W-1:0] w_last,
  input logic [WORD_W-1:0] w_total,
  input logic              ovf,
  input logic              valid
);
  localparam int unsigned PAD_W = WORD_W - CNT_W;
  localparam logic [CNT_W-1:0] CMAX = '1;

  AST_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (w_sync[PAD_W-1:0] | w_first[PAD_W-1:0] | w_last[PAD_W-1:0] | w_total[PAD_W-1:0]) == '0); // R6

  AST_HOLD_OUTSIDE_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    !vs_lead |=> ($stable(w_sync) && $stable(w_first) && $stable(w_last) && $stable(w_total) && $stable(ovf))); // R5

  AST_LINE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && !vs_lead && cnt != CMAX) |=> cnt == $past(cnt) + 1'b1); // R2

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && !vs_lead && cnt == CMAX) |=> cnt == CMAX); // R7

  AST_RESTART_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    vs_lead |=> cnt == (($past(hs)) ? CNT_W'(1) : CNT_W'(0))); // R8

  AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> valid); // R9

  AST_VALID_ON_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> valid); // R9
endmodule

bind vline_meter vlm_checker #(.CNT_W(CNT_W), .WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .hs(hs_pulse), .vs_lead(vs_lead_pulse), .xfer(xfer),
  .cnt(line_cnt), .w_sync(rd_sync_width), .w_first(rd_first_act),
  .w_last(rd_last_act), .w_total(rd_frame_lines), .ovf(rd_overflow), .valid(rd_valid)
);

// File: tb/vline_meter_tb.sv
`timescale 1ns/100ps
module vline_meter_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hs = 0, vl = 0, vt = 0, af = 0, al = 0;
  logic [15:0] w_sync, w_first, w_last, w_total;
  logic ovf, valid;

  int checks = 0, failures = 0;
  bit done = 0;

  // behavioural reference state
  int m_cnt = 0, m_ovf = 0, m_armed = 0;
  int m_b[3] = '{0, 0, 0};
  int r_b[3] = '{0, 0, 0};
  int r_total = 0, r_ovf = 0, r_valid = 0;

  always #2.5 clk = ~clk;

  vline_meter u_dut (
    .clk(clk), .rst_n(rst_n), .hs_pulse(hs), .vs_lead_pulse(vl),
    .vs_trail_pulse(vt), .act_first_pulse(af), .act_last_pulse(al),
    .rd_sync_width(w_sync), .rd_first_act(w_first), .rd_last_act(w_last),
    .rd_frame_lines(w_total), .rd_overflow(ovf), .rd_valid(valid)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R3 rd_sync_width", int'(w_sync), r_b[0] * 16);
    chk("R4 rd_first_act", int'(w_first), r_b[1] * 16);
    chk("R4 rd_last_act", int'(w_last), r_b[2] * 16);
    chk("R2 rd_frame_lines", int'(w_total), r_total * 16);
    chk("R7 rd_overflow", int'(ovf), r_ovf);
    chk("R9 rd_valid", int'(valid), r_valid);
  endtask

  task automatic step(input bit h, input bit l, input bit t, input bit f, input bit e);
    @(negedge clk);
    hs = h; vl = l; vt = t; af = f; al = e;
    @(posedge clk);
    if (l) begin
      if (m_armed != 0) begin
        r_b = m_b; r_total = m_cnt; r_ovf = m_ovf; r_valid = 1;
      end
      m_armed = 1;
      m_cnt = h ? 1 : 0;
      m_ovf = 0;
      m_b = '{0, 0, 0};
    end else if (h) begin
      if (m_cnt >= 4095) m_ovf = 1;
      else m_cnt = m_cnt + 1;
    end
    if (t) m_b[0] = m_cnt;
    if (f) m_b[1] = m_cnt;
    if (e) m_b[2] = m_cnt;
    #1;
    compare_all();
  endtask

  // lines: hs pulses; markers placed on given line numbers (0 = none);
  // gap idle clocks after each line; mark2 gives a second first-active marker.
  task automatic frame(input int lines, input int ts, input int fa, input int la,
                       input int gap, input int fa2, input bit hs_on_lead);
    for (int n = 1; n <= lines; n++) begin
      step(1'b1, 1'b0, n == ts, (n == fa) || (n == fa2), n == la);
      for (int g = 0; g < gap; g++) step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    end
    step(hs_on_lead, 1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    compare_all(); // R1 reset state
    rst_n = 1'b1;
    // partial frame then first leading edge: no transfer (R9)
    for (int n = 0; n < 5; n++) step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R9 no transfer on first lead", int'(valid), 0);
    // regular frame, trailing edge off a line pulse
    for (int n = 1; n <= 25; n++) begin
      step(1'b1, 1'b0, 1'b0, n == 5, n == 20);
      step(1'b0, 1'b0, n == 3, 1'b0, 1'b0); // R3 trail between lines
    end
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R2 frame total", int'(w_total), 25 * 16);
    chk("R3 sync width", int'(w_sync), 3 * 16);
    chk("R9 valid after first complete frame", int'(valid), 1);
    // markers coincident with line pulses, repeated first marker, hs on lead
    frame(30, 4, 6, 28, 1, 9, 1'b1);
    chk("R4 repeated first marker keeps last", int'(w_first), 9 * 16);
    chk("R4 last active", int'(w_last), 28 * 16);
    // frame starting with coincident hs: total counts it as line 1 (R8)
    frame(10, 2, 0, 0, 0, 0, 1'b0);
    chk("R8 coincident pulse is line 1", int'(w_total), 11 * 16);
    chk("R4 absent marker is zero", int'(w_first), 0);
    // overflow frame (R7)
    frame(4100, 2, 3, 4098, 0, 0, 1'b0);
    chk("R7 saturated total", int'(w_total), 4095 * 16);
    chk("R7 overflow flag", int'(ovf), 1);
    chk("R7 last marker saturated", int'(w_last), 4095 * 16);
    frame(12, 1, 2, 11, 0, 0, 1'b0);
    chk("R7 overflow cleared", int'(ovf), 0);
    chk("R6 low bits zero", int'(w_total[3:0]), 0);
    // alternating frame lengths reported as counted (R2)
    for (int k = 0; k < 6; k++) begin
      frame(40 + (k % 2), 3, 5, 38, k % 3, 0, 1'b0);
      chk("R2 alternating length", int'(w_total), (40 + (k % 2)) * 16);
    end
    // long idle: read words hold (R5)
    for (int n = 0; n < 20; n++) step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R5 hold while idle", int'(w_total), 41 * 16);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule